// File: doc/BRIEF.md
# Byte-Serial Cipher Program Loader

This block links a 32-bit authenticated-encryption datapath to a small 8-bit processor that runs a block cipher in software. The processor shares two memories with the block: a program memory and a 32-byte data memory. For each job, the datapath names a cipher with a 4-bit code. The block writes that cipher's program image into program memory, but only when the code differs from the cipher already resident. It then turns eight 32-bit words (four key words, then four state words) into a stream of tagged bytes written into data memory, one per cycle. It pulses a start strobe to the processor and waits for its done strobe. Finally it reads the 16-byte result back and repacks it into four 32-bit words.

Each byte on the data-memory write channel carries a 2-bit header that tells the memory side whether it is state, key or control. The control byte holds the cipher code and is sent once at the start of every job. Program images are computed constants, so no ROM content is stored as a table.

Top module: `cipher_loader`

## Requirements
- R1: After synchronous reset, busy, err, pm_we, bt_valid, core_start and res_valid are all 0. No cipher counts as resident, so the first valid job always reloads the program.
- R2: Codes 0, 1 and 2 are valid (2 selects the AES-based mode, 1 the CHAM-based mode and 0 the GIFT-based mode). An idle command with a code from 3 to 15 raises err for exactly one cycle. It leaves busy at 0, writes nothing, and does not change the resident cipher.
- R3: One cycle after a valid command is accepted, one control byte is sent before any other write. Its header is 2'b10 and its value is {4'b0000, code}. The memory side does not store it.
- R4: When the code differs from the resident cipher, PROG_LEN program bytes are written to program addresses 0, 1, ... in order before any key byte. Byte i of cipher c is (37*i + 85*c + 3) mod 256. When the code matches, no program byte is written.
- R5: Input words are accepted with wr_valid/wr_ready: four key words first, then four state words. Each word is split most-significant byte first.
- R6: Key bytes go to data addresses 0x10..0x1F with header 2'b01. State bytes go to 0x00..0x0F with header 2'b00. Both go in ascending address order, and all key bytes come before all state bytes.
- R7: core_start is a single-cycle pulse in the cycle after the last state byte (address 0x0F) is presented. The block then waits for core_done.
- R8: After core_done, data addresses 0x00..0x0F are read with a synchronous 1-cycle read. Every four bytes form one result word (the lower address in the most-significant byte), marked by a one-cycle res_valid. After the fourth word, busy drops.
- R9: A command given while busy is ignored. It does not alter the running job or the resident cipher.
- R10: When each next word is offered no later than the cycle its predecessor's last byte goes out, the 32 key and state bytes occupy 32 consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a job (accepted only when idle) |
| cmd_code | input | CODE_W | Cipher code of the job |
| wr_valid | input | 1 | Input word offered |
| wr_word | input | WORD_W | Key or state word |
| wr_ready | output | 1 | Word is taken at the next edge when wr_valid is high |
| busy | output | 1 | Job in progress |
| err | output | 1 | One-cycle pulse on an invalid code |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | PA_W | Program memory address |
| pm_data | output | 8 | Program byte |
| bt_valid | output | 1 | Tagged byte present |
| bt_hdr | output | 2 | Byte header: 00 state, 01 key, 10 control |
| bt_addr | output | DA_W | Data memory address |
| bt_data | output | 8 | Byte value |
| core_start | output | 1 | Start pulse to the processor |
| core_done | input | 1 | Processor finished |
| dm_raddr | output | RA_W | Data memory read address |
| dm_rdata | input | 8 | Data memory read byte (one cycle after the address) |
| res_valid | output | 1 | Result word valid |
| res_word | output | WORD_W | Result word |

## Verification
The hardest condition to reach is a job that must skip the program reload right after events that could have corrupted the resident-cipher register: a sweep over every invalid code, and a foreign command issued in the middle of a job. The bench produces this by following such events with a job using the resident code, then counting program writes and checking the computed result, which depends on the program bytes in memory. The gap-free byte stream is the other delicate point. It is reached by feeding words with zero gap, so that each new word is taken in the same cycle the previous word's last byte leaves.

// File: rtl/cl_pkg.sv
package cl_pkg;

  typedef enum logic [1:0] {
    HDR_DATA = 2'b00,
    HDR_KEY  = 2'b01,
    HDR_CTRL = 2'b10
  } hdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_PROG, S_XFER, S_START, S_RUN, S_READ
  } ld_state_t;

  localparam int PROG_MUL_IDX  = 37;
  localparam int PROG_MUL_CODE = 85;
  localparam int PROG_OFS      = 3;

  // program image byte i for cipher c, computed instead of stored
  function automatic logic [7:0] prog_byte(input int c, input int i);
    int v;
    v = PROG_MUL_IDX * i + PROG_MUL_CODE * c + PROG_OFS;
    return v[7:0];
  endfunction

endpackage

// File: rtl/cl_prog_rom.sv
module cl_prog_rom #(
  parameter int CODE_W   = 4,
  parameter int PROG_LEN = 16,
  localparam int PA_W    = $clog2(PROG_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [PA_W-1:0]   idx,
  output logic              pm_we,
  output logic [PA_W-1:0]   pm_addr,
  output logic [7:0]        pm_data
);
  import cl_pkg::*;

  // registered read, one program byte per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pm_we   <= 1'b0;
      pm_addr <= '0;
      pm_data <= '0;
    end else begin
      pm_we   <= en;
      pm_addr <= idx;
      pm_data <= prog_byte(int'(code), int'(idx));
    end
  end

  // R4
  prog_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_we && $past(pm_we)) |-> (pm_addr == $past(pm_addr) + PA_W'(1)));

endmodule

// File: rtl/cl_serializer.sv
module cl_serializer #(
  parameter int WORD_W    = 32,
  parameter int BLK_BYTES = 16,
  localparam int WPB      = WORD_W / 8,
  localparam int XBYTES   = 2 * BLK_BYTES,
  localparam int NWORDS   = XBYTES / WPB,
  localparam int DA_W     = $clog2(XBYTES),
  localparam int SC_W     = $clog2(WPB + 1),
  localparam int WC_W     = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              active,
  input  logic              ctrl_send,
  input  logic [7:0]        ctrl_byte,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_ready,
  output logic              bt_valid,
  output logic [1:0]        bt_hdr,
  output logic [DA_W-1:0]   bt_addr,
  output logic [7:0]        bt_data,
  output logic              last_launch
);
  import cl_pkg::*;

  logic [WORD_W-1:0] sh;
  logic [SC_W-1:0]   sh_cnt;
  logic [WC_W-1:0]   wcnt;
  logic [DA_W-1:0]   xidx;
  logic              emit, take, is_key;

  assign emit        = (sh_cnt != '0);
  assign wr_ready    = active && (wcnt != WC_W'(NWORDS)) && (sh_cnt <= SC_W'(1));
  assign take        = wr_ready && wr_valid;
  assign is_key      = (xidx < DA_W'(BLK_BYTES));
  assign last_launch = emit && (xidx == DA_W'(XBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_cnt   <= '0;
      wcnt     <= '0;
      xidx     <= '0;
      bt_valid <= 1'b0;
      bt_hdr   <= HDR_DATA;
      bt_addr  <= '0;
      bt_data  <= '0;
      sh       <= '0;
    end else begin
      bt_valid <= ctrl_send || emit;
      if (ctrl_send) begin
        bt_hdr  <= HDR_CTRL;
        bt_addr <= '0;
        bt_data <= ctrl_byte;
      end else if (emit) begin
        bt_hdr  <= is_key ? HDR_KEY : HDR_DATA;
        bt_addr <= is_key ? xidx + DA_W'(BLK_BYTES) : xidx - DA_W'(BLK_BYTES);
        bt_data <= sh[WORD_W-1 -: 8];
        xidx    <= xidx + DA_W'(1);
      end
      if (take) begin
        sh     <= wr_word;
        sh_cnt <= SC_W'(WPB);
        wcnt   <= wcnt + WC_W'(1);
      end else if (emit) begin
        sh     <= sh << 8;
        sh_cnt <= sh_cnt - SC_W'(1);
      end
    end
  end

  // R6
  key_region_chk: assert property (@(posedge clk) disable iff (rst)
    (bt_valid && bt_hdr == HDR_KEY) |-> (bt_addr >= DA_W'(BLK_BYTES)));

  // R6
  data_region_chk: assert property (@(posedge clk) disable iff (rst)
    (bt_valid && bt_hdr == HDR_DATA) |-> (bt_addr < DA_W'(BLK_BYTES)));

endmodule

// File: rtl/cl_packer.sv
module cl_packer #(
  parameter int WORD_W    = 32,
  parameter int BLK_BYTES = 16,
  localparam int WPB      = WORD_W / 8,
  localparam int NW       = BLK_BYTES / WPB,
  localparam int RA_W     = $clog2(BLK_BYTES),
  localparam int RC_W     = $clog2(BLK_BYTES + 1),
  localparam int BC_W     = $clog2(WPB),
  localparam int WC_W     = $clog2(NW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [RA_W-1:0]   dm_raddr,
  input  logic [7:0]        dm_rdata,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              res_last
);

  logic              issuing, rq_v, mv;
  logic [RC_W-1:0]   rcnt;
  logic [BC_W-1:0]   bcnt;
  logic [WC_W-1:0]   wcnt;
  logic [WORD_W-9:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing   <= 1'b0;
      rq_v      <= 1'b0;
      mv        <= 1'b0;
      rcnt      <= '0;
      bcnt      <= '0;
      wcnt      <= '0;
      acc       <= '0;
      dm_raddr  <= '0;
      res_valid <= 1'b0;
      res_last  <= 1'b0;
      res_word  <= '0;
    end else begin
      rq_v      <= issuing;
      mv        <= rq_v;
      res_valid <= 1'b0;
      res_last  <= 1'b0;
      if (start) begin
        issuing <= 1'b1;
        rcnt    <= '0;
        bcnt    <= '0;
        wcnt    <= '0;
      end else if (issuing) begin
        dm_raddr <= rcnt[RA_W-1:0];
        rcnt     <= rcnt + RC_W'(1);
        if (rcnt == RC_W'(BLK_BYTES - 1)) issuing <= 1'b0;
      end
      if (mv) begin
        acc  <= {acc[WORD_W-17:0], dm_rdata};
        bcnt <= bcnt + BC_W'(1);
        if (bcnt == BC_W'(WPB - 1)) begin
          res_valid <= 1'b1;
          res_word  <= {acc, dm_rdata};
          wcnt      <= wcnt + WC_W'(1);
          res_last  <= (wcnt == WC_W'(NW - 1));
        end
      end
    end
  end

  // R8
  word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

endmodule

// File: rtl/cipher_loader.sv
module cipher_loader #(
  parameter int CODE_W      = 4,
  parameter int WORD_W      = 32,
  parameter int BLK_BYTES   = 16,
  parameter int PROG_LEN    = 16,
  parameter int NUM_CIPHERS = 3,
  localparam int PA_W       = $clog2(PROG_LEN),
  localparam int DA_W       = $clog2(2 * BLK_BYTES),
  localparam int RA_W       = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_ready,
  output logic              busy,
  output logic              err,
  output logic              pm_we,
  output logic [PA_W-1:0]   pm_addr,
  output logic [7:0]        pm_data,
  output logic              bt_valid,
  output logic [1:0]        bt_hdr,
  output logic [DA_W-1:0]   bt_addr,
  output logic [7:0]        bt_data,
  output logic              core_start,
  input  logic              core_done,
  output logic [RA_W-1:0]   dm_raddr,
  input  logic [7:0]        dm_rdata,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word
);
  import cl_pkg::*;

  localparam logic [CODE_W-1:0] NONE = {CODE_W{1'b1}};

  ld_state_t         state;
  logic [CODE_W-1:0] code_q, resident;
  logic [PA_W-1:0]   pidx;
  logic              code_ok, accept, last_launch, res_last, pk_start;

  assign code_ok  = (cmd_code < CODE_W'(NUM_CIPHERS));
  assign accept   = (state == S_IDLE) && cmd_valid && code_ok;
  assign pk_start = (state == S_RUN) && core_done;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      code_q     <= '0;
      resident   <= NONE;
      pidx       <= '0;
      err        <= 1'b0;
      core_start <= 1'b0;
    end else begin
      err        <= 1'b0;
      core_start <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            code_q <= cmd_code;
            state  <= S_CTRL;
          end else if (cmd_valid) begin
            err <= 1'b1;
          end
        end
        S_CTRL: begin
          pidx  <= '0;
          state <= (code_q == resident) ? S_XFER : S_PROG;
        end
        S_PROG: begin
          pidx <= pidx + PA_W'(1);
          if (pidx == PA_W'(PROG_LEN - 1)) begin
            resident <= code_q;
            state    <= S_XFER;
          end
        end
        S_XFER:  if (last_launch) state <= S_START;
        S_START: begin
          core_start <= 1'b1;
          state      <= S_RUN;
        end
        S_RUN:   if (core_done) state <= S_READ;
        S_READ:  if (res_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  cl_prog_rom #(.CODE_W(CODE_W), .PROG_LEN(PROG_LEN)) u_rom (
    .clk(clk), .rst(rst), .en(state == S_PROG), .code(code_q), .idx(pidx),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data)
  );

  cl_serializer #(.WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES)) u_ser (
    .clk(clk), .rst(rst), .clear(accept), .active(state == S_XFER),
    .ctrl_send(state == S_CTRL), .ctrl_byte(8'(code_q)),
    .wr_valid(wr_valid), .wr_word(wr_word), .wr_ready(wr_ready),
    .bt_valid(bt_valid), .bt_hdr(bt_hdr), .bt_addr(bt_addr), .bt_data(bt_data),
    .last_launch(last_launch)
  );

  cl_packer #(.WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES)) u_pack (
    .clk(clk), .rst(rst), .start(pk_start), .dm_raddr(dm_raddr),
    .dm_rdata(dm_rdata), .res_valid(res_valid), .res_word(res_word),
    .res_last(res_last)
  );

  // R2
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  // R4
  prog_before_data_chk: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> !bt_valid);

  // R7
  start_after_last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |-> ($past(bt_valid) && $past(bt_addr) == DA_W'(BLK_BYTES - 1)));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  // R8
  result_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (state == S_READ));

endmodule

// File: tb/cipher_loader_test.sv
module cipher_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100000;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, wr_valid = 0, core_done = 0;
  logic [3:0]  cmd_code = 0;
  logic [31:0] wr_word = 0;
  logic wr_ready, busy, err, pm_we, bt_valid, core_start, res_valid;
  logic [3:0] pm_addr, dm_raddr;
  logic [7:0] pm_data, bt_data, dm_rdata;
  logic [1:0] bt_hdr;
  logic [4:0] bt_addr;
  logic [31:0] res_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_loader uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_valid(wr_valid), .wr_word(wr_word), .wr_ready(wr_ready), .busy(busy),
    .err(err), .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data),
    .bt_valid(bt_valid), .bt_hdr(bt_hdr), .bt_addr(bt_addr), .bt_data(bt_data),
    .core_start(core_start), .core_done(core_done), .dm_raddr(dm_raddr),
    .dm_rdata(dm_rdata), .res_valid(res_valid), .res_word(res_word)
  );

  int checks = 0, errors = 0, cyc = 0;

  function automatic logic [7:0] prog(input int c, input int i);
    int v; v = 37 * i + 85 * c + 3; return v[7:0];
  endfunction
  function automatic logic [7:0] keyb(input int s, input int i);
    int v; v = s * 29 + i * 13 + 5; return v[7:0];
  endfunction
  function automatic logic [7:0] datab(input int s, input int i);
    int v; v = (s * 71) ^ (i * 19 + 100); return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory and processor model
  logic [7:0] dm [0:31];
  logic [7:0] pm [0:15];
  int ccnt = 0, lat = 5;
  always @(posedge clk) begin
    if (bt_valid && bt_hdr != 2'b10) dm[bt_addr] <= bt_data;
    if (pm_we) pm[pm_addr] <= pm_data;
    dm_rdata  <= dm[dm_raddr];
    core_done <= 1'b0;
    if (core_start) ccnt <= lat;
    else if (ccnt > 1) ccnt <= ccnt - 1;
    else if (ccnt == 1) begin
      ccnt <= 0;
      core_done <= 1'b1;
      for (int i = 0; i < 16; i++) dm[i] <= dm[i] ^ dm[16 + i] ^ pm[i];
    end
  end

  // monitor
  int cur_code = 0, cur_seed = 0, seq = 0, stream_bad = 0, ctrl_cnt = 0, ctrl_bad = 0;
  int pm_cnt = 0, pm_bad = 0, res_cnt = 0, bubbles = 0, starts = 0, act = 0;
  logic [31:0] res_w [0:3];

  always @(negedge clk) if (!rst) begin
    if (pm_we) begin
      act++;
      if (pm_data != prog(cur_code, int'(pm_addr)) || int'(pm_addr) != pm_cnt || seq != 0
          || ctrl_cnt != 1) pm_bad++;
      pm_cnt++;
    end
    if (bt_valid) begin
      act++;
      if (bt_hdr == 2'b10) begin
        ctrl_cnt++;
        if (bt_data != 8'(cur_code) || seq != 0 || pm_cnt != 0) ctrl_bad++;
      end else begin
        if (seq < 16) begin
          if (bt_hdr != 2'b01 || int'(bt_addr) != 16 + seq || bt_data != keyb(cur_seed, seq))
            stream_bad++;
        end else begin
          if (bt_hdr != 2'b00 || int'(bt_addr) != seq - 16 || bt_data != datab(cur_seed, seq - 16))
            stream_bad++;
        end
        if (ctrl_cnt == 0) stream_bad++;
        seq++;
      end
    end else if (seq > 0 && seq < 32) bubbles++;
    if (core_start) begin
      act++; starts++;
      if (seq != 32) stream_bad++;
    end
    if (res_valid) begin
      if (res_cnt < 4) res_w[res_cnt] = res_word;
      res_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int resident = -1;

  task automatic run_job(input int code, input int seed, input int gap,
                         input bit intr, input int alt);
    logic [31:0] w;
    bit reload;
    reload = (code != resident);
    cur_code = code; cur_seed = seed; seq = 0; stream_bad = 0; ctrl_cnt = 0;
    ctrl_bad = 0; pm_cnt = 0; pm_bad = 0; res_cnt = 0; bubbles = 0; starts = 0;
    lat = 3 + seed % 5;
    @(negedge clk);
    cmd_valid = 1; cmd_code = 4'(code);
    @(negedge clk);
    cmd_valid = 0;
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 4; b++)
        w[31 - 8*b -: 8] = (k < 4) ? keyb(seed, 4*k + b) : datab(seed, 4*(k-4) + b);
      if (intr && k == 2) begin cmd_valid = 1; cmd_code = 4'(alt); end
      wr_valid = 1; wr_word = w;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 0; cmd_valid = 0;
      repeat (gap) @(negedge clk);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(ctrl_cnt == 1 && ctrl_bad == 0, "R3", "control byte", ctrl_bad, 0);
    chk(pm_cnt == (reload ? 16 : 0), "R4", "program byte count", pm_cnt, reload ? 16 : 0);
    chk(pm_bad == 0, "R4", "program byte content/order", pm_bad, 0);
    chk(seq == 32 && stream_bad == 0, "R6", "key/state byte stream (R5 word split)",
        stream_bad, 0);
    chk(starts == 1, "R7", "core start pulses", starts, 1);
    chk(res_cnt == 4, "R8", "result word count", res_cnt, 4);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) begin
        int i; i = 4*k + b;
        e[31 - 8*b -: 8] = datab(seed, i) ^ keyb(seed, i) ^ prog(code, i);
      end
      chk(res_w[k] == e, "R8", "result word", res_w[k], e);
    end
    if (gap == 0) chk(bubbles == 0, "R10", "gaps in byte stream", bubbles, 0);
    resident = code;
  endtask

  task automatic bad_code(input int code);
    act = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_code = 4'(code);
    @(negedge clk);
    cmd_valid = 0;
    chk(err == 1 && busy == 0, "R2", "err pulse on invalid code", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 0, "R2", "err single cycle", err, 0);
    chk(act == 0, "R2", "no activity on invalid code", act, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk({busy, err, pm_we, bt_valid, core_start, res_valid} == 6'b0, "R1",
        "reset outputs", {busy, err, pm_we, bt_valid, core_start, res_valid}, 0);
    run_job(2, 1, 0, 0, 0);          // R1 first job reloads
    run_job(2, 2, 1, 0, 0);          // R4 skip
    run_job(1, 3, 5, 1, 0);          // R9 foreign command mid-job
    run_job(1, 4, 0, 0, 0);          // R9 resident unchanged
    run_job(0, 5, 2, 0, 0);
    for (int c = 3; c < 16; c++) bad_code(c);
    run_job(0, 6, 0, 0, 0);          // R2 resident unchanged after sweep
    run_job(2, 7, 3, 0, 0);
    run_job(0, 8, 0, 1, 2);
    run_job(0, 9, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule